// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

The block takes interrupt events from client sources through a valid/ready handshake. It packs each event into a vector of eight 32-bit words and writes that vector into a circular buffer in memory through a word-write port. The write pointer and read pointer are byte offsets into the ring. The ring holds a power-of-two number of dwords, set by a log2 size field. Software consumes vectors and then reports its progress by writing the read pointer register.

The block raises an interrupt line while unread vectors are present. When a new vector lands on the read position, the block sets a sticky overflow flag in bit 31 of the write-pointer register. It keeps writing after an overflow, so the oldest entries are overwritten. Software clears the flag through a write-one bit in the control register and resumes reading one vector past the write pointer. Software can also enable a mirror of the write-pointer register, which is then written to a separate writeback address after each vector.

Top module: `ivr_writer`

## Requirements
- R1: After reset, evt_ready_o, irq_o and mem_we_o are 0, and the read and write pointer registers read 0.
- R2: Registers are selected by reg_addr_i: 0 control, 1 ring base, 2 read pointer, 3 write pointer, 4 writeback address. In the control register, bit 0 is ring enable, bit 1 is interrupt enable, bit 2 is overflow enable, bit 3 is overflow clear and bit 4 is writeback enable. evt_ready_o is high only when bits 0 and 1 are both set and no vector is being written. An accepted event produces eight consecutive word writes that start in the next cycle, and evt_ready_o stays low throughout.
- R3: The word layout is fixed. Word 0 is {vmid_src, 3'b0, vmid[3:0], ring[7:0], src[7:0], client[7:0]}. Word 1 is timestamp[31:0]. Word 2 is {ts_src, 15'b0, timestamp[47:32]}. Word 3 is {pasid_src, 15'b0, pasid[15:0]}. Words 4 to 7 are data[31:0], data[63:32], data[95:64] and data[127:96].
- R4: Word i of a vector goes to byte address base + wptr + 4*i. After each vector the write pointer advances by 32, modulo a ring of 4<<N bytes. N is control bits [12:8], clamped to the range 3 to MAX_LOG2.
- R5: When overflow is enabled and the advanced write pointer equals the read pointer, bit 31 of the write-pointer register sets. The bit stays set, and writing continues.
- R6: With overflow enable clear, the overflow bit never sets.
- R7: Writing a control value with bit 3 set clears the overflow bit. Bit 3 reads back as 0.
- R8: With writeback enabled, one extra word equal to the write-pointer register value, including bit 31, is written to the writeback address right after the eight vector words.
- R9: irq_o is high exactly when interrupt enable is set and the write pointer differs from the read pointer.
- R10: Writes to the pointer registers load the written value masked to the ring size. The write pointer is also aligned down to 32 bytes. This lets software disable the block and zero both pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event valid |
| evt_ready_o | output | 1 | Event accepted when high with valid |
| evt_client_i | input | 8 | Client id |
| evt_src_i | input | 8 | Source id |
| evt_ring_i | input | 8 | Ring id |
| evt_vmid_i | input | 4 | Virtual machine id |
| evt_vmid_src_i | input | 1 | Vmid source flag |
| evt_ts_i | input | 48 | Timestamp |
| evt_ts_src_i | input | 1 | Timestamp source flag |
| evt_pasid_i | input | 16 | Process address space id |
| evt_pasid_src_i | input | 1 | Pasid source flag |
| evt_data_i | input | 128 | Four words of source data |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_we_o | output | 1 | Memory word write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every cycle. Ready is never high while a word is being written. An accepted event starts a burst in the next cycle. The write pointer stays 32-byte aligned and only moves by one vector, modulo the ring, unless software loads it. The overflow flag stays set until it is cleared, and it rises only when overflow is enabled. The bench scenarios are needed for the rest: the exact word contents and addresses, where the ring wraps for each size, the cycle on which overflow fires, the writeback word, the recovery sequence and the interrupt level. For these, the bench sweeps every small ring size, with writeback both on and off.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int VEC_WORDS = 8;
  localparam int VEC_BYTES = 32;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_BASE   = 3'd1;
  localparam logic [2:0] A_RPTR   = 3'd2;
  localparam logic [2:0] A_WPTR   = 3'd3;
  localparam logic [2:0] A_WBADDR = 3'd4;

  localparam int CB_RING   = 0;
  localparam int CB_INTR   = 1;
  localparam int CB_OVFEN  = 2;
  localparam int CB_OVFCLR = 3;
  localparam int CB_WB     = 4;
  localparam int CB_SZ_LO  = 8;
  localparam int SZ_W      = 5;
  localparam int MIN_LOG2  = 3;

  typedef struct packed {
    logic [7:0]       client;
    logic [7:0]       src;
    logic [7:0]       ring;
    logic [3:0]       vmid;
    logic             vmid_src;
    logic [47:0]      ts;
    logic             ts_src;
    logic [15:0]      pasid;
    logic             pasid_src;
    logic [3:0][31:0] data;
  } ivr_event_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_WB} eng_state_e;
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int MAX_LOG2 = 16,
  parameter int PTR_W    = MAX_LOG2 + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [PTR_W-1:0] wptr_i,
  input  logic             ovf_i,
  output logic [31:0]      rdata_o,
  output logic             ring_en_o,
  output logic             intr_en_o,
  output logic             ovf_en_o,
  output logic             ovf_clr_o,
  output logic             wb_en_o,
  output logic [PTR_W-1:0] mask_o,
  output logic [31:0]      base_o,
  output logic [31:0]      wb_addr_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic             sw_wptr_we_o,
  output logic [PTR_W-1:0] sw_wptr_o
);
  logic [SZ_W-1:0] size_q, size_eff;
  logic [PTR_W:0]  span;
  logic [PTR_W:0]  mask_full;
  logic            wr_ctrl;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_en_o <= 1'b0;
      intr_en_o <= 1'b0;
      ovf_en_o  <= 1'b0;
      wb_en_o   <= 1'b0;
      size_q    <= SZ_W'(MIN_LOG2);
      base_o    <= '0;
      wb_addr_o <= '0;
      rptr_o    <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: begin
          ring_en_o <= wdata_i[CB_RING];
          intr_en_o <= wdata_i[CB_INTR];
          ovf_en_o  <= wdata_i[CB_OVFEN];
          wb_en_o   <= wdata_i[CB_WB];
          size_q    <= wdata_i[CB_SZ_LO +: SZ_W];
        end
        A_BASE:   base_o    <= wdata_i;
        A_RPTR:   rptr_o    <= wdata_i[PTR_W-1:0] & mask_o;
        A_WBADDR: wb_addr_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (size_q < SZ_W'(MIN_LOG2))      size_eff = SZ_W'(MIN_LOG2);
    else if (size_q > SZ_W'(MAX_LOG2)) size_eff = SZ_W'(MAX_LOG2);
    else                               size_eff = size_q;
    span      = (PTR_W+1)'(1) << (size_eff + SZ_W'(2));
    mask_full = span - (PTR_W+1)'(1);
  end
  assign mask_o = mask_full[PTR_W-1:0];

  assign ovf_clr_o    = wr_ctrl && wdata_i[CB_OVFCLR];
  assign sw_wptr_we_o = we_i && (addr_i == A_WPTR);
  assign sw_wptr_o    = wdata_i[PTR_W-1:0] & mask_o & ~PTR_W'(VEC_BYTES - 1);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CB_RING]           = ring_en_o;
        rdata_o[CB_INTR]           = intr_en_o;
        rdata_o[CB_OVFEN]          = ovf_en_o;
        rdata_o[CB_WB]             = wb_en_o;
        rdata_o[CB_SZ_LO +: SZ_W]  = size_q;
      end
      A_BASE:   rdata_o = base_o;
      A_RPTR:   rdata_o = 32'(rptr_o);
      A_WPTR:   rdata_o = {ovf_i, (31-PTR_W)'(0), wptr_i};
      A_WBADDR: rdata_o = wb_addr_o;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ivr_pack.sv
module ivr_pack
  import ivr_pkg::*;
(
  input  ivr_event_t                  evt_i,
  output logic [VEC_WORDS-1:0][31:0]  words_o
);
  assign words_o[0] = {evt_i.vmid_src, 3'b000, evt_i.vmid, evt_i.ring, evt_i.src, evt_i.client};
  assign words_o[1] = evt_i.ts[31:0];
  assign words_o[2] = {evt_i.ts_src, 15'd0, evt_i.ts[47:32]};
  assign words_o[3] = {evt_i.pasid_src, 15'd0, evt_i.pasid};

  for (genvar g = 0; g < 4; g++) begin : g_data
    assign words_o[4+g] = evt_i.data[g];
  end
endmodule

// File: rtl/ivr_engine.sv
module ivr_engine
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        run_i,
  input  logic                        ovf_en_i,
  input  logic                        ovf_clr_i,
  input  logic                        wb_en_i,
  input  logic [PTR_W-1:0]            mask_i,
  input  logic [31:0]                 base_i,
  input  logic [31:0]                 wb_addr_i,
  input  logic [PTR_W-1:0]            rptr_i,
  input  logic                        sw_wptr_we_i,
  input  logic [PTR_W-1:0]            sw_wptr_i,
  input  logic                        evt_valid_i,
  output logic                        evt_ready_o,
  input  logic [VEC_WORDS-1:0][31:0]  vec_i,
  output logic                        mem_we_o,
  output logic [31:0]                 mem_addr_o,
  output logic [31:0]                 mem_wdata_o,
  output logic [PTR_W-1:0]            wptr_o,
  output logic                        ovf_o
);
  localparam int BEAT_W = $clog2(VEC_WORDS);

  eng_state_e                 state_q;
  logic [BEAT_W-1:0]          beat_q;
  logic [VEC_WORDS-1:0][31:0] vec_q;
  logic [PTR_W-1:0]           wptr_q, next_wptr;
  logic                       ovf_q;
  logic                       last_beat, hit;

  assign evt_ready_o = run_i && (state_q == ST_IDLE);
  assign next_wptr   = (wptr_q + PTR_W'(VEC_BYTES)) & mask_i;
  assign last_beat   = (state_q == ST_BEAT) && (beat_q == BEAT_W'(VEC_WORDS - 1));
  assign hit         = last_beat && ovf_en_i && (next_wptr == rptr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      vec_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (evt_valid_i && evt_ready_o) begin
          vec_q   <= vec_i;
          beat_q  <= '0;
          state_q <= ST_BEAT;
        end
        ST_BEAT: begin
          beat_q <= beat_q + BEAT_W'(1);
          if (last_beat) state_q <= wb_en_i ? ST_WB : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // software load wins over the hardware advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (sw_wptr_we_i)   wptr_q <= sw_wptr_i;
      else if (last_beat) wptr_q <= next_wptr;
      ovf_q <= (ovf_q && !ovf_clr_i) || hit;
    end
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (state_q == ST_BEAT) begin
      mem_we_o    = 1'b1;
      mem_addr_o  = base_i + 32'(wptr_q + {beat_q, 2'b00});
      mem_wdata_o = vec_q[beat_q];
    end else if (state_q == ST_WB) begin
      mem_we_o    = 1'b1;
      mem_addr_o  = wb_addr_i;
      mem_wdata_o = {ovf_q, (31-PTR_W)'(0), wptr_q};
    end
  end

  assign wptr_o = wptr_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int MAX_LOG2 = 16,
  parameter int PTR_W    = MAX_LOG2 + 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_valid_i,
  output logic         evt_ready_o,
  input  logic [7:0]   evt_client_i,
  input  logic [7:0]   evt_src_i,
  input  logic [7:0]   evt_ring_i,
  input  logic [3:0]   evt_vmid_i,
  input  logic         evt_vmid_src_i,
  input  logic [47:0]  evt_ts_i,
  input  logic         evt_ts_src_i,
  input  logic [15:0]  evt_pasid_i,
  input  logic         evt_pasid_src_i,
  input  logic [127:0] evt_data_i,
  input  logic         reg_we_i,
  input  logic [2:0]   reg_addr_i,
  input  logic [31:0]  reg_wdata_i,
  output logic [31:0]  reg_rdata_o,
  output logic         mem_we_o,
  output logic [31:0]  mem_addr_o,
  output logic [31:0]  mem_wdata_o,
  output logic         irq_o
);
  ivr_event_t                 evt;
  logic [VEC_WORDS-1:0][31:0] vec;
  logic                       ring_en, intr_en, ovf_en, ovf_clr, wb_en;
  logic [PTR_W-1:0]           mask, rptr, wptr, sw_wptr;
  logic                       sw_wptr_we, ovf;
  logic [31:0]                base, wb_addr;

  always_comb begin
    evt.client    = evt_client_i;
    evt.src       = evt_src_i;
    evt.ring      = evt_ring_i;
    evt.vmid      = evt_vmid_i;
    evt.vmid_src  = evt_vmid_src_i;
    evt.ts        = evt_ts_i;
    evt.ts_src    = evt_ts_src_i;
    evt.pasid     = evt_pasid_i;
    evt.pasid_src = evt_pasid_src_i;
    evt.data      = evt_data_i;
  end

  ivr_pack u_pack (.evt_i(evt), .words_o(vec));

  ivr_regs #(.MAX_LOG2(MAX_LOG2), .PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .wptr_i(wptr), .ovf_i(ovf), .rdata_o(reg_rdata_o),
    .ring_en_o(ring_en), .intr_en_o(intr_en), .ovf_en_o(ovf_en),
    .ovf_clr_o(ovf_clr), .wb_en_o(wb_en), .mask_o(mask),
    .base_o(base), .wb_addr_o(wb_addr), .rptr_o(rptr),
    .sw_wptr_we_o(sw_wptr_we), .sw_wptr_o(sw_wptr)
  );

  ivr_engine #(.PTR_W(PTR_W)) u_eng (
    .clk_i, .rst_ni,
    .run_i(ring_en && intr_en), .ovf_en_i(ovf_en), .ovf_clr_i(ovf_clr),
    .wb_en_i(wb_en), .mask_i(mask), .base_i(base), .wb_addr_i(wb_addr),
    .rptr_i(rptr), .sw_wptr_we_i(sw_wptr_we), .sw_wptr_i(sw_wptr),
    .evt_valid_i, .evt_ready_o, .vec_i(vec),
    .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .wptr_o(wptr), .ovf_o(ovf)
  );

  assign irq_o = intr_en && (wptr != rptr);
endmodule

// File: rtl/ivr_writer_chk.sv
module ivr_writer_chk #(
  parameter int PTR_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic             evt_ready_o,
  input logic             mem_we_o,
  input logic [PTR_W-1:0] wptr,
  input logic [PTR_W-1:0] mask,
  input logic             ovf,
  input logic             ovf_en,
  input logic             ovf_clr,
  input logic             sw_wptr_we
);
  p_ready_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !evt_ready_o);

  p_burst_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_ready_o) |=> mem_we_o);

  p_wptr_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr[4:0] == 5'd0);

  p_wptr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wptr) |-> ($past(sw_wptr_we) ||
                        wptr == (($past(wptr) + PTR_W'(32)) & $past(mask))));

  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !ovf_clr) |=> ovf);

  p_ovf_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf) |-> $past(ovf_en));
endmodule

bind ivr_writer ivr_writer_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i),
  .evt_ready_o(evt_ready_o), .mem_we_o(mem_we_o), .wptr(wptr), .mask(mask),
  .ovf(ovf), .ovf_en(ovf_en), .ovf_clr(ovf_clr), .sw_wptr_we(sw_wptr_we)
);

// File: tb/ivr_writer_tb_top.sv
`timescale 1ns/1ps
module ivr_writer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_valid = 1'b0;
  logic         evt_ready;
  logic [7:0]   client, src, ring;
  logic [3:0]   vmid;
  logic         vmid_src, ts_src, pasid_src;
  logic [47:0]  ts;
  logic [15:0]  pasid;
  logic [127:0] data;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [31:0]  reg_wdata = 32'd0;
  logic [31:0]  reg_rdata;
  logic         mem_we;
  logic [31:0]  mem_addr, mem_wdata;
  logic         irq;

  int tests = 0, fails = 0, wcnt = 0;
  bit done = 0;
  logic [31:0] mem [0:1023];

  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] WBA  = 32'h380;

  always #2 clk = ~clk;

  ivr_writer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_valid_i(evt_valid), .evt_ready_o(evt_ready),
    .evt_client_i(client), .evt_src_i(src), .evt_ring_i(ring),
    .evt_vmid_i(vmid), .evt_vmid_src_i(vmid_src), .evt_ts_i(ts),
    .evt_ts_src_i(ts_src), .evt_pasid_i(pasid), .evt_pasid_src_i(pasid_src),
    .evt_data_i(data), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model and busy-ready monitor
  always @(negedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:2]] = mem_wdata;
      wcnt++;
      if (evt_ready) begin
        fails++;
        $display("FAIL R2 ready=%b exp=0 during write", evt_ready);
      end
    end
  end

  function automatic logic [31:0] exp_word(input int k, input int i);
    logic [7:0]  c = 8'(k*3+1), s = 8'(k+16), r = 8'(k ^ 32'h5A);
    logic [47:0] t = {16'(k*32'h1111), 32'(k*32'h01010101 + 7)};
    logic [15:0] p = 16'(k*32'h123 + 9);
    case (i)
      0: return {k[0], 3'b000, 4'(k), r, s, c};
      1: return t[31:0];
      2: return {k[1], 15'd0, t[47:32]};
      3: return {k[2], 15'd0, p};
      default: return 32'(k)*32'h11111111 + 32'(i);
    endcase
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #0.5 v = reg_rdata;
  endtask

  task automatic send(input int k, output int n);
    client = 8'(k*3+1); src = 8'(k+16); ring = 8'(k ^ 32'h5A);
    vmid = 4'(k); vmid_src = k[0];
    ts = {16'(k*32'h1111), 32'(k*32'h01010101 + 7)}; ts_src = k[1];
    pasid = 16'(k*32'h123 + 9); pasid_src = k[2];
    for (int i = 0; i < 4; i++) data[32*i +: 32] = exp_word(k, 4+i);
    @(negedge clk);
    evt_valid = 1'b1;
    while (!evt_ready) @(negedge clk);
    wcnt = 0;
    @(posedge clk);
    #1 evt_valid = 1'b0;
    for (int t = 0; t < 20 && !evt_ready; t++) @(negedge clk);
    @(negedge clk);
    n = wcnt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, msk, mw, mr, exp_wp;
    int k, n;
    logic mo;
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    k = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", {31'd0, evt_ready}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
    rst_n = 1'b1;
    rd(3'd3, v); chk("R1 wptr", v, 32'd0);
    rd(3'd2, v); chk("R1 rptr", v, 32'd0);

    wr(3'd1, BASE);
    wr(3'd4, WBA);
    // R2: ready needs both enables
    wr(3'd0, 32'h1);
    chk("R2 ring only", {31'd0, evt_ready}, 32'd0);
    wr(3'd0, 32'h2);
    chk("R2 intr only", {31'd0, evt_ready}, 32'd0);
    wr(3'd0, 32'h3 | (32'd3 << 8));
    chk("R2 both", {31'd0, evt_ready}, 32'd1);
    rd(3'd0, v); chk("R7 ctrl readback", v, 32'h303);

    // sweep ring sizes and writeback
    for (int s = 3; s <= 5; s++) begin
      for (int wb = 0; wb < 2; wb++) begin
        // R10: disable and zero the pointers
        wr(3'd0, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd0, 32'h8);
        rd(3'd3, v); chk("R10 wptr zero", v, 32'd0);
        rd(3'd2, v); chk("R10 rptr zero", v, 32'd0);
        chk("R10 irq off", {31'd0, irq}, 32'd0);
        wr(3'd0, (32'(s) << 8) | (32'(wb) << 4) | 32'h7);
        msk = (32'd4 << s) - 1; mw = 0; mr = 0; mo = 0;
        for (int m = 0; m < (1 << (s-3)) + 1; m++) begin
          k++;
          send(k, n);
          chk("R2/R8 write count", 32'(n), 32'(8 + wb));
          for (int i = 0; i < 8; i++)
            chk("R3/R4 vector word", mem[10'((BASE + mw + 32'(4*i)) >> 2)], exp_word(k, i));
          mw = (mw + 32) & msk;
          if (mw == mr) mo = 1;
          exp_wp = {mo, 31'(mw)};
          rd(3'd3, v); chk("R4/R5 wptr reg", v, exp_wp);
          if (wb == 1) chk("R8 writeback", mem[10'(WBA >> 2)], exp_wp);
          chk("R9 irq", {31'd0, irq}, {31'd0, mw != mr});
        end
        chk("R5 overflow set", {31'd0, mo}, 32'd1);
        // recovery: skip to oldest intact entry, clear flag
        wr(3'd2, (mw + 32) & msk);
        wr(3'd0, (32'(s) << 8) | (32'(wb) << 4) | 32'hF);
        rd(3'd3, v); chk("R7 overflow cleared", v, mw);
        rd(3'd2, v); chk("R10 rptr masked", v, (mw + 32) & msk);
        wr(3'd2, mw);
        chk("R9 irq drained", {31'd0, irq}, 32'd0);
      end
    end

    // R6 plus size clamp: size field 1 acts as 3 (32-byte ring)
    wr(3'd0, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd0, 32'h8);
    wr(3'd0, (32'd1 << 8) | 32'h3);
    k++;
    send(k, n);
    chk("R4 clamp word0", mem[10'(BASE >> 2)], exp_word(k, 0));
    rd(3'd3, v); chk("R6 no overflow", v, 32'd0);
    chk("R9 irq equal ptrs", {31'd0, irq}, 32'd0);
    // R10: wptr write aligned and masked
    wr(3'd0, (32'd5 << 8) | 32'h3);
    wr(3'd3, 32'hFFFF_FF47);
    rd(3'd3, v); chk("R10 wptr align", v, 32'h40);
    chk("R9 irq pending", {31'd0, irq}, 32'd1);
    wr(3'd0, (32'd5 << 8) | 32'h1);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule